// File: doc/BRIEF.md
# Serial SAR ADC Read Controller

This block sits on the host side of a three-wire link to a successive-approximation converter. On a start request it raises the convert-start line and holds it for a programmed number of system clocks while the converter works. It then drops the line and reads the 12-bit result from the converter's serial data line. The converter puts its most significant bit on the data line as soon as convert-start falls. Each later bit appears on a falling edge of the serial clock, so eleven falling edges deliver the rest of the word and there is no result latency.

The controller divides the system clock to make the serial clock. One half period lasts `div_i + 1` system clocks. The serial clock stays low whenever the controller is idle or the converter is busy. The controller samples each bit one half period after it was launched: the most significant bit just before the first rising edge of the serial clock, and every other bit on the rising edge that follows its launching falling edge. The assembled word is presented with a one-cycle strobe. The divider setting and the conversion count are captured when a request is accepted, so the host can change them freely while a read is in progress.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset and whenever idle (`busy_o` low), `conv_o`, `sck_o` and `valid_o` are low.
- R2: A `start_i` sampled high while idle sets `conv_o` and `busy_o` at that edge. `conv_o` then stays high for exactly max(`conv_cnt_i`, 1) system clocks.
- R3: `sck_o` is low during every cycle in which `conv_o` is high.
- R4: `div_i + 1` system clocks after `conv_o` falls, `sdo_i` is captured as bit 11 (the MSB) and `sck_o` rises. Every later `sck_o` level is held for `div_i + 1` system clocks.
- R5: Each of the next 11 falling edges of `sck_o` is followed one half period later by a rising edge, and `sdo_i` is captured there. The bits are assembled MSB first, bit 0 last. Exactly 11 falling edges occur before the result is strobed.
- R6: `valid_o` is high for exactly one cycle, with `data_o` equal to the 12 captured bits. If the request is sampled at edge E0, `valid_o` is high in the cycle that follows edge E0 + N + 23·(div+1), where N = max(conv_cnt, 1).
- R7: One half period after the last capture, `sck_o` falls (its 12th falling edge) and `busy_o` drops at edge E0 + N + 24·(div+1).
- R8: `start_i` is ignored while `busy_o` is high, so no second conversion follows the current one.
- R9: `div_i` and `conv_cnt_i` are taken only when a request is accepted. Changing them while busy does not alter the timing of the read in progress.
- R10: `data_o` keeps its value in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and readout |
| div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| conv_cnt_i | input | CNT_W | Convert-start high time in system clocks (0 acts as 1) |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert-start line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | A conversion or readout is in progress |

## Verification
Every timed result has a fixed offset from the edge that accepts the request. Call that edge E0, let N be the effective conversion count and h the half period. `conv_o` is high for N cycles. The strobe follows edge E0 + N + 23h, and busy clears at edge E0 + N + 24h. The bench counts system clocks from the cycle after E0 and samples every output on the falling system edge. It compares the cycle numbers it observes with these formulas, which it computes from the settings it applied, not from the values it scrambles in mid-read. A behavioural converter model launches bits on the edges of `conv_o` and `sck_o`. Against that model, the bench checks how many serial clock falls occur before the strobe and in total, and verifies that the word and the idle lines hold steady for several cycles after each read.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_MSB,
    ST_SCK_HI,
    ST_SCK_LO,
    ST_TAIL
  } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  // count restarts from zero whenever disabled, so each phase is div+1 long
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $stable(div_i) |-> cnt_q <= div_i) else $error("tick counter overran divider"); // R4
endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_o <= '0;
    else if (clr_i) word_o <= '0;
    else if (cap_i) word_o <= {word_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  conv_cnt_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  rd_state_e         state_q;
  logic              conv_q, sck_q, valid_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  ccnt_q, lim_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] data_q, shw;
  logic              tick, tick_en, accept, cap, last;

  assign tick_en = (state_q == ST_WAIT_MSB) || (state_q == ST_SCK_HI) ||
                   (state_q == ST_SCK_LO)   || (state_q == ST_TAIL);
  assign accept  = (state_q == ST_IDLE) && start_i;
  assign cap     = tick && ((state_q == ST_WAIT_MSB) || (state_q == ST_SCK_LO));
  assign last    = cap && (bit_q == BIT_W'(DATA_W - 1));

  adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_rd_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cap_i  (cap),
    .bit_i  (sdo_i),
    .word_o (shw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      conv_q  <= 1'b0;
      sck_q   <= 1'b0;
      valid_q <= 1'b0;
      bit_q   <= '0;
      ccnt_q  <= '0;
      lim_q   <= CNT_W'(1);
      div_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= last;
      if (last) data_q <= {shw[DATA_W-2:0], sdo_i};
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          conv_q  <= 1'b1;
          ccnt_q  <= '0;
          bit_q   <= '0;
          div_q   <= div_i;
          lim_q   <= (conv_cnt_i == '0) ? CNT_W'(1) : conv_cnt_i;
        end
        ST_CONV: begin
          if (ccnt_q == lim_q - CNT_W'(1)) begin
            conv_q  <= 1'b0;
            state_q <= ST_WAIT_MSB;
          end else begin
            ccnt_q <= ccnt_q + CNT_W'(1);
          end
        end
        // MSB is already on the line; take it before the first clock edge
        ST_WAIT_MSB: if (tick) begin
          sck_q   <= 1'b1;
          bit_q   <= BIT_W'(1);
          state_q <= ST_SCK_HI;
        end
        ST_SCK_HI: if (tick) begin
          sck_q   <= 1'b0;
          state_q <= ST_SCK_LO;
        end
        ST_SCK_LO: if (tick) begin
          sck_q   <= 1'b1;
          bit_q   <= bit_q + BIT_W'(1);
          state_q <= last ? ST_TAIL : ST_SCK_HI;
        end
        ST_TAIL: if (tick) begin
          sck_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o  = conv_q;
  assign sck_o   = sck_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign busy_o  = (state_q != ST_IDLE);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !conv_o && !sck_o && !valid_o) else $error("lines active while idle"); // R1
  AST_CONV_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> busy_o) else $error("conv without busy"); // R2
  AST_SCK_LOW_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !sck_o) else $error("sck toggled during conversion"); // R3
  AST_BIT_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_W'(DATA_W)) else $error("bit counter overran"); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R6
  AST_VALID_WITH_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sck_o && busy_o) else $error("valid outside final high phase"); // R7
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> !$past(busy_o)) else $error("conversion restarted while busy"); // R8
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(div_q)) else $error("divider changed mid read"); // R9
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)) else $error("data moved without valid"); // R10
endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  div_i = '0;
  logic [15:0] conv_cnt_i = '0;
  logic        sdo = 1'b0;
  logic        conv_o, sck_o, valid_o, busy_o;
  logic [11:0] data_o;
  logic [11:0] adc_word = '0;
  logic [11:0] adc_sh = '0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .div_i      (div_i),
    .conv_cnt_i (conv_cnt_i),
    .sdo_i      (sdo),
    .conv_o     (conv_o),
    .sck_o      (sck_o),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .busy_o     (busy_o)
  );

  // converter model: MSB on conv fall, next bit on each sck fall, zeros after LSB
  always @(negedge conv_o) begin
    adc_sh = adc_word;
    sdo    = adc_sh[11];
  end
  always @(negedge sck_o) begin
    adc_sh = {adc_sh[10:0], 1'b0};
    sdo    = adc_sh[11];
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_valid_cyc(input int d, input int n);
    return ((n == 0) ? 1 : n) + 23 * (d + 1) + 1;
  endfunction

  function automatic int exp_idle_cyc(input int d, input int n);
    return ((n == 0) ? 1 : n) + 24 * (d + 1) + 1;
  endfunction

  task automatic run_tx(input logic [11:0] w, input int d, input int n);
    int cyc = 0, convhi = 0, falls = 0, falls_v = 0, vcnt = 0, vcyc = 0, idle_cyc = 0;
    int np = (n == 0) ? 1 : n;
    bit prev_sck = 1'b0, sck_in_conv = 1'b0;
    logic [11:0] got = '0;
    adc_word   = w;
    div_i      = 8'(d);
    conv_cnt_i = 16'(n);
    start_i    = 1'b1;
    while (idle_cyc == 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start_i = 1'b0;
      if (cyc == 3) begin
        start_i    = 1'b1;                 // R8 request while busy
        div_i      = 8'($urandom_range(0, 9));   // R9 scramble settings
        conv_cnt_i = 16'($urandom_range(0, 60));
      end
      if (cyc == 4) start_i = 1'b0;
      if (conv_o) convhi++;
      if (conv_o && sck_o) sck_in_conv = 1'b1;
      if (prev_sck && !sck_o) falls++;
      prev_sck = sck_o;
      if (valid_o) begin
        vcnt++;
        if (vcnt == 1) begin vcyc = cyc; falls_v = falls; got = data_o; end
      end
      if (!busy_o) idle_cyc = cyc;
    end
    chk("R2 conv high cycles", convhi == np, convhi, np);
    chk("R3 sck low in conv", !sck_in_conv, int'(sck_in_conv), 0);
    chk("R5 falls before valid", falls_v == 11, falls_v, 11);
    chk("R4 R5 data word", got == w, int'(got), int'(w));
    chk("R6 valid cycle", vcyc == exp_valid_cyc(d, n), vcyc, exp_valid_cyc(d, n));
    chk("R6 valid width", vcnt == 1, vcnt, 1);
    chk("R7 busy drop cycle", idle_cyc == exp_idle_cyc(d, n), idle_cyc, exp_idle_cyc(d, n));
    chk("R7 total falls", falls == 12, falls, 12);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 no restart", !conv_o && !busy_o, int'(conv_o), 0);
      chk("R1 idle lines", !sck_o && !valid_o, int'(sck_o), 0);
      chk("R10 data held", data_o == w, int'(data_o), int'(w));
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 reset conv", !conv_o, int'(conv_o), 0);
    chk("R1 reset sck", !sck_o, int'(sck_o), 0);
    chk("R1 reset busy", !busy_o && !valid_o, int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_tx(12'hFFF, 0, 0);   // R2 zero count acts as one
    run_tx(12'h000, 0, 1);
    run_tx(12'hA5A, 1, 3);
    run_tx(12'h5A5, 7, 40);
    run_tx(12'h801, 3, 2);   // R5 MSB and LSB only
    run_tx(12'h001, 2, 17);
    for (int t = 0; t < 20; t++)
      run_tx(12'($urandom), int'($urandom_range(0, 4)), int'($urandom_range(0, 45)));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule